// File: doc/BRIEF.md
# USB Device Control Register Unit

This unit is the byte-wide control and status register that a CPU uses to run a USB device engine. It keeps five control bits: ping-pong pointer reset, packet-processing halt, module enable, resume signalling and suspend. It also shows the bus single-ended-zero state as a read-only bit. Software reaches it over a simple register bus: one address-decoded write strobe, write data, and read data that is always valid.

Several bits are partly driven by hardware. A SETUP token from the engine halts packet processing, and software can only lift that halt. Enable is refused while the engine clock is not valid. The rising edge of enable sends out a single-cycle strobe that clears the ping-pong indicators in the buffer descriptor table. Every strobe and level that goes to the engine is held inactive while the module is disabled.

Top module: `usbctl_reg_unit`

## Requirements
- R1: After reset, every writable bit reads 0, and every output to the engine (`ppb_reset`, `ppbi_clear_pulse`, `pullup_en`, `sie_clk_en`, `resume_drive`, `pkt_proc_enable`) is 0.
- R2: Read data layout: bit 6 ppb-reset, bit 5 SE0 status, bit 4 packet halt, bit 3 enable, bit 2 resume, bit 1 suspend. Bits 7 and 0 always read 0, whatever was written to them.
- R3: While enable is 1, `ppb_reset` equals read bit 6. It holds every ping-pong pointer at the even bank.
- R4: Read bit 5 follows `se0_live` with exactly `SYNC_STAGES` (default 2) clock cycles of latency. Writes to bit 5 have no effect.
- R5: A `setup_token_pulse` sets bit 4. A write with bit 4 = 0 clears it. A write with bit 4 = 1 never sets it. If a SETUP pulse and a clearing write arrive in the same cycle, the bit ends up 1. `pkt_proc_enable` is enable AND NOT bit 4.
- R6: A write with bit 3 = 1 while `clock_valid` is 0 leaves enable unchanged. A write with bit 3 = 0 always clears enable.
- R7: Each 0-to-1 transition of enable gives `ppbi_clear_pulse` for exactly one cycle: the first cycle in which enable reads 1. `pullup_en` equals enable.
- R8: While enable is 0, `ppb_reset`, `sie_clk_en`, `resume_drive` and `pkt_proc_enable` are all 0.
- R9: While enable is 1, `sie_clk_en` is the inverse of the suspend bit (bit 1).
- R10: While enable is 1, `resume_drive` equals the resume bit (bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr_en | input | 1 | Address-decoded write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| clock_valid | input | 1 | Engine clock source is active |
| setup_token_pulse | input | 1 | One-cycle SETUP token indication from the engine |
| se0_live | input | 1 | Raw single-ended-zero state of the bus |
| ppb_reset | output | 1 | Hold ping-pong pointers at even bank |
| ppbi_clear_pulse | output | 1 | One-cycle strobe that clears ping-pong indicators |
| pullup_en | output | 1 | Soft-attach pull-up enable |
| sie_clk_en | output | 1 | Engine clock enable |
| resume_drive | output | 1 | Drive resume signalling |
| pkt_proc_enable | output | 1 | Token and packet processing allowed |

## Verification
The assertions assume that `setup_token_pulse` and `clock_valid` are synchronous to `clk`, and that `se0_live` may change at any cycle. The enable-gating assertion assumes `clock_valid` was sampled in the same cycle as the write. The bench changes every input only on the falling clock edge. It asserts the SETUP pulse for exactly one cycle, and it toggles `clock_valid` only between register writes, so every sampled value is stable.

// File: rtl/usbctl_pkg.sv
package usbctl_pkg;
  localparam int REG_W       = 8;
  localparam int POS_PPBRST  = 6;
  localparam int POS_SE0     = 5;
  localparam int POS_HALT    = 4;
  localparam int POS_EN      = 3;
  localparam int POS_RESUME  = 2;
  localparam int POS_SUSP    = 1;

  typedef struct packed {
    logic ppbrst;
    logic halt;
    logic en;
    logic resume;
    logic susp;
  } ctl_bits_t;
endpackage

// File: rtl/usbctl_se0_sync.sv
module usbctl_se0_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d[0] = d_in;
    for (int i = 1; i < STAGES; i++) sh_d[i] = sh_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_out = sh_q[STAGES-1];
endmodule

// File: rtl/usbctl_bit_regs.sv
module usbctl_bit_regs
  import usbctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             clock_valid,
  input  logic             setup_pulse,
  output ctl_bits_t        bits_q
);
  ctl_bits_t bits_d;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) begin
      bits_d.ppbrst = wdata[POS_PPBRST];
      bits_d.resume = wdata[POS_RESUME];
      bits_d.susp   = wdata[POS_SUSP];
      if (!wdata[POS_HALT]) bits_d.halt = 1'b0;
      if (!wdata[POS_EN])   bits_d.en   = 1'b0;
      else if (clock_valid) bits_d.en   = 1'b1;
    end
    if (setup_pulse) bits_d.halt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= bits_d;
  end

  a_r6_en_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bits_q.en) |-> $past(clock_valid));
  a_r5_setup_sets_halt: assert property (@(posedge clk) disable iff (!rst_n)
    setup_pulse |=> bits_q.halt);
  a_r5_sw_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!bits_q.halt && !setup_pulse) |=> !bits_q.halt);
endmodule

// File: rtl/usbctl_effects.sv
module usbctl_effects
  import usbctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ctl_bits_t bits_q,
  output logic      ppb_reset,
  output logic      ppbi_clear_pulse,
  output logic      pullup_en,
  output logic      sie_clk_en,
  output logic      resume_drive,
  output logic      pkt_proc_enable
);
  logic en_seen_q;
  logic en_seen_d;

  assign en_seen_d = bits_q.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen_q <= 1'b0;
    else        en_seen_q <= en_seen_d;
  end

  always_comb begin
    ppbi_clear_pulse = bits_q.en & ~en_seen_q;
    pullup_en        = bits_q.en;
    ppb_reset        = bits_q.en & bits_q.ppbrst;
    sie_clk_en       = bits_q.en & ~bits_q.susp;
    resume_drive     = bits_q.en & bits_q.resume;
    pkt_proc_enable  = bits_q.en & ~bits_q.halt;
  end

  a_r7_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ppbi_clear_pulse |=> !ppbi_clear_pulse);
  a_r7_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pullup_en) |-> ppbi_clear_pulse);
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pullup_en |-> !(ppb_reset || sie_clk_en || resume_drive || pkt_proc_enable));
endmodule

// File: rtl/usbctl_reg_unit.sv
module usbctl_reg_unit
  import usbctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             clock_valid,
  input  logic             setup_token_pulse,
  input  logic             se0_live,
  output logic             ppb_reset,
  output logic             ppbi_clear_pulse,
  output logic             pullup_en,
  output logic             sie_clk_en,
  output logic             resume_drive,
  output logic             pkt_proc_enable
);
  ctl_bits_t bits_q;
  logic      se0_sync;

  usbctl_bit_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .wdata       (reg_wdata),
    .clock_valid (clock_valid),
    .setup_pulse (setup_token_pulse),
    .bits_q      (bits_q)
  );

  usbctl_se0_sync #(.STAGES(SYNC_STAGES)) u_se0 (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (se0_live),
    .q_out (se0_sync)
  );

  usbctl_effects u_fx (
    .clk              (clk),
    .rst_n            (rst_n),
    .bits_q           (bits_q),
    .ppb_reset        (ppb_reset),
    .ppbi_clear_pulse (ppbi_clear_pulse),
    .pullup_en        (pullup_en),
    .sie_clk_en       (sie_clk_en),
    .resume_drive     (resume_drive),
    .pkt_proc_enable  (pkt_proc_enable)
  );

  always_comb begin
    reg_rdata             = '0;
    reg_rdata[POS_PPBRST] = bits_q.ppbrst;
    reg_rdata[POS_SE0]    = se0_sync;
    reg_rdata[POS_HALT]   = bits_q.halt;
    reg_rdata[POS_EN]     = bits_q.en;
    reg_rdata[POS_RESUME] = bits_q.resume;
    reg_rdata[POS_SUSP]   = bits_q.susp;
  end

  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[7] == 1'b0) && (reg_rdata[0] == 1'b0));
endmodule

// File: tb/test_usbctl_reg_unit.sv
`timescale 1ns/1ps
module test_usbctl_reg_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       clock_valid = 1'b0;
  logic       setup_token_pulse = 1'b0;
  logic       se0_live = 1'b0;
  logic       ppb_reset, ppbi_clear_pulse, pullup_en, sie_clk_en, resume_drive, pkt_proc_enable;

  typedef struct {
    logic [7:0] rd;
    logic [5:0] outs;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;

  usbctl_reg_unit i_usbctl_reg_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clock_valid(clock_valid),
    .setup_token_pulse(setup_token_pulse), .se0_live(se0_live),
    .ppb_reset(ppb_reset), .ppbi_clear_pulse(ppbi_clear_pulse),
    .pullup_en(pullup_en), .sie_clk_en(sie_clk_en),
    .resume_drive(resume_drive), .pkt_proc_enable(pkt_proc_enable)
  );

  // outs = {ppb_reset, ppbi_clear_pulse, pullup_en, sie_clk_en, resume_drive, pkt_proc_enable}
  always begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      exp_t e;
      logic [5:0] act;
      e   = exp_q.pop_front();
      act = {ppb_reset, ppbi_clear_pulse, pullup_en, sie_clk_en, resume_drive, pkt_proc_enable};
      n_vec++;
      if (act !== e.outs || reg_rdata !== e.rd) begin
        n_bad++;
        $display("FAIL %s: rdata %h outs %b expected %h %b", e.tag, reg_rdata, act, e.rd, e.outs);
      end
    end
  end

  task automatic expect_now(input logic [7:0] rd, input logic [5:0] outs, input string tag);
    exp_t e;
    e.rd = rd; e.outs = outs; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d, input bit with_setup);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wdata = d; setup_token_pulse = with_setup;
    @(negedge clk);
    reg_wr_en = 1'b0; setup_token_pulse = 1'b0;
  endtask

  task automatic setup_pulse();
    @(negedge clk);
    setup_token_pulse = 1'b1;
    @(negedge clk);
    setup_token_pulse = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    expect_now(8'h00, 6'b000000, "R1 reset state");

    wr(8'hFF, 0);
    expect_now(8'h46, 6'b000000, "R2 R6 R8 R5 write all ones without clock");

    clock_valid = 1'b1;
    wr(8'h4E, 0);
    expect_now(8'h4E, 6'b111011, "R7 R3 R9 R10 enable rise with suspend");
    tick();
    expect_now(8'h4E, 6'b101011, "R7 pulse lasts one cycle");

    wr(8'h08, 0);
    expect_now(8'h08, 6'b001101, "R9 R3 running unsuspended");

    setup_pulse();
    expect_now(8'h18, 6'b001100, "R5 setup sets halt");
    wr(8'h18, 0);
    expect_now(8'h18, 6'b001100, "R5 write one keeps halt");
    wr(8'h08, 0);
    expect_now(8'h08, 6'b001101, "R5 write zero clears halt");
    wr(8'h08, 1);
    expect_now(8'h18, 6'b001100, "R5 hardware set wins over clear");

    se0_live = 1'b1;
    tick();
    expect_now(8'h18, 6'b001100, "R4 se0 not yet visible");
    tick();
    expect_now(8'h38, 6'b001100, "R4 se0 visible after two cycles");

    wr(8'h20, 0);
    expect_now(8'h20, 6'b000000, "R4 R8 R6 disable and write to se0 bit");

    clock_valid = 1'b0;
    wr(8'h08, 0);
    expect_now(8'h20, 6'b000000, "R6 enable refused without clock");

    clock_valid = 1'b1;
    wr(8'h08, 0);
    expect_now(8'h28, 6'b011101, "R7 second enable rise pulses");
    tick();
    expect_now(8'h28, 6'b001101, "R7 pulse ends");

    clock_valid = 1'b0;
    wr(8'h08, 0);
    expect_now(8'h28, 6'b001101, "R6 R7 enable held, no new pulse");

    tick(); tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule